// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Block with Delayed Interrupts

This block is the software-visible register face of a classic byte-wide serial port. A host reaches eight byte registers through a 3-bit offset. A select strobe and a write flag qualify each access. The block holds the line-control, interrupt-enable and modem-control bytes and a 16-bit divisor. It hands received bytes from a valid/ready character source to the host. Transmit bytes leave on a one-cycle strobe. Bit timing, baud generation, FIFOs and modem lines are not part of the block, and the divisor is only stored.

A single interrupt line is raised by two independent delay timers, one for received data and one for transmitter-empty. Each timer is armed by register traffic. Arming a timer that is already running restarts it. When a timer runs out, its source posts only if that source is still enabled. The identification register reports the source, and receive outranks transmit. Reading the identification register retires a transmit indication.

Top module: `serial_reg_port`

## Requirements
- R1: When bit 7 of the line-control byte (offset 3) is set, offsets 0 and 1 read and write the divisor low and high bytes. Offset 4 reads back the modem-control byte last written. A write to offset 0 in this state produces no transmit strobe.
- R2: With bit 7 clear, a read of offset 0 returns rxData and pulses rxReady in the same cycle when rxValid is high. When rxValid is low it returns 0x00 and rxReady stays low.
- R3: With bit 7 clear, a write of offset 0 pulses txStrobe for that cycle, with txData equal to the written byte.
- R4: An armed timer raises irq exactly IRQ_DELAY (default 450) clock edges after the edge that armed it. Arming it again while it runs restarts the full delay.
- R5: A write of the enable register (offset 1, bit 7 clear) arms the transmit timer when bit 1 is set. It arms the receive timer when bit 0 is set and rxValid is high. For each source that is not armed this way, the write cancels that source's timer, clears its pending status and drops irq.
- R6: On expiry, irq and the source's pending status are set only if the source's enable bit is set. irq then stays high until a data read, a data write or an enable-register write clears it.
- R7: A read of offset 2 returns 0x04 while receive is pending, else 0x02 while transmit is pending, else 0x01. The read clears transmit pending and leaves irq unchanged.
- R8: A data read drops irq and clears receive pending. If rxValid is high in the following cycle and enable bit 0 is set, the receive timer is armed at the next edge. irq then rises IRQ_DELAY+1 edges after the read.
- R9: A data write drops irq and clears transmit pending, and it arms the transmit timer when enable bit 1 is set.
- R10: Offset 5 reads 0x60 with bit 0 equal to rxValid.
- R11: Offsets 6 and 7 read 0x00. Writes to offsets 2 and 7 change no register and no output.
- R12: After reset all stored bytes are zero, irq is low and offset 2 reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access strobe, one access per high cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte, valid while busSel is high |
| rxValid | input | 1 | Character source holds a byte |
| rxData | input | 8 | Byte offered by the source |
| rxReady | output | 1 | Byte taken by the host this cycle |
| txStrobe | output | 1 | Transmit byte emitted this cycle |
| txData | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports has both sources pending at once, which the identification priority needs. The stimulus gets there with one enable-register write that sets both enable bits while the source holds a byte. That write arms both timers on the same edge, so they expire together. Restart is shown by a second data write inside the delay window. irq must then stay low where the first arming would have fired. The receive re-arm after a data read is timed to the edge that follows the read.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int NUM_SRC = 2;

  // source index doubles as enable-register bit position
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;

  localparam int CTRL_DIV_BIT = 7;
  localparam int LSR_DR_BIT   = 0;
  localparam int LSR_THRE_BIT = 5;
  localparam int LSR_TEMT_BIT = 6;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IID  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LCR  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCR  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSR  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSR  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

  localparam logic [BYTE_W-1:0] IID_RX   = 8'h04;
  localparam logic [BYTE_W-1:0] IID_TX   = 8'h02;
  localparam logic [BYTE_W-1:0] IID_NONE = 8'h01;

  typedef enum logic [3:0] {
    SEL_RXDATA, SEL_DIVLO, SEL_IER, SEL_DIVHI, SEL_IID,
    SEL_LCR, SEL_MCR, SEL_LSR, SEL_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   wrLcr;
    logic   wrIer;
    logic   wrMcr;
    logic   wrDivLo;
    logic   wrDivHi;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int DELAY = 450
) (
  input  logic clk,
  input  logic rstN,
  input  logic arm,
  input  logic cancel,
  output logic expire
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic [CW-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (arm)            cntQ <= LOAD;
    else if (cancel)         cntQ <= '0;
    else if (cntQ != '0)     cntQ <= cntQ - LAST;
  end

  // a restart or cancel in the final cycle suppresses the expiry
  assign expire = (cntQ == LAST) && !arm && !cancel;
endmodule

// File: rtl/serial_reg_ctrl.sv
module serial_reg_ctrl
  import serial_reg_pkg::*;
#(
  parameter int IRQ_DELAY = 450
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [NUM_SRC-1:0]   ierBits,
  input  logic                 rxValid,
  input  logic                 dlab,
  input  logic [NUM_SRC-1:0]   srcEn,
  output regStrobe_t           strobe,
  output logic [NUM_SRC-1:0]   pend,
  output logic                 irq,
  output logic                 rxReady,
  output logic                 txStrobe
);
  logic rdAcc, wrAcc, dataRd, dataWr, ierWr, iidRd;
  logic recheckQ;
  logic irqQ;
  logic irqD;
  logic [NUM_SRC-1:0] pendQ, pendD;
  logic [NUM_SRC-1:0] tmrArm, tmrCancel, tmrExpire;

  assign rdAcc  = busSel && !busWr;
  assign wrAcc  = busSel && busWr;
  assign dataRd = rdAcc && (busAddr == OFS_DATA) && !dlab;
  assign dataWr = wrAcc && (busAddr == OFS_DATA) && !dlab;
  assign ierWr  = wrAcc && (busAddr == OFS_IER) && !dlab;
  assign iidRd  = rdAcc && (busAddr == OFS_IID);

  assign rxReady  = dataRd && rxValid;
  assign txStrobe = dataWr;

  always_comb begin
    strobe         = '0;
    strobe.wrLcr   = wrAcc && (busAddr == OFS_LCR);
    strobe.wrIer   = ierWr;
    strobe.wrMcr   = wrAcc && (busAddr == OFS_MCR);
    strobe.wrDivLo = wrAcc && (busAddr == OFS_DATA) && dlab;
    strobe.wrDivHi = wrAcc && (busAddr == OFS_IER) && dlab;
    case (busAddr)
      OFS_DATA: strobe.rdSel = dlab ? SEL_DIVLO : SEL_RXDATA;
      OFS_IER:  strobe.rdSel = dlab ? SEL_DIVHI : SEL_IER;
      OFS_IID:  strobe.rdSel = SEL_IID;
      OFS_LCR:  strobe.rdSel = SEL_LCR;
      OFS_MCR:  strobe.rdSel = SEL_MCR;
      OFS_LSR:  strobe.rdSel = SEL_LSR;
      default:  strobe.rdSel = SEL_ZERO;
    endcase
  end

  // timer control per source
  always_comb begin
    tmrArm[SRC_TX]    = (ierWr && ierBits[SRC_TX]) || (dataWr && srcEn[SRC_TX]);
    tmrCancel[SRC_TX] = ierWr && !ierBits[SRC_TX];
    tmrArm[SRC_RX]    = (ierWr && ierBits[SRC_RX] && rxValid) ||
                        (recheckQ && rxValid && srcEn[SRC_RX]);
    tmrCancel[SRC_RX] = ierWr && !(ierBits[SRC_RX] && rxValid);
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : gTmr
    irq_delay_timer #(.DELAY(IRQ_DELAY)) uTmr (
      .clk    (clk),
      .rstN   (rstN),
      .arm    (tmrArm[s]),
      .cancel (tmrCancel[s]),
      .expire (tmrExpire[s])
    );
  end

  always_comb begin
    pendD = pendQ;
    irqD  = irqQ;
    if (dataRd) begin
      irqD          = 1'b0;
      pendD[SRC_RX] = 1'b0;
    end
    if (dataWr) begin
      irqD          = 1'b0;
      pendD[SRC_TX] = 1'b0;
    end
    if (iidRd) pendD[SRC_TX] = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (tmrCancel[s]) begin
        irqD     = 1'b0;
        pendD[s] = 1'b0;
      end
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (tmrExpire[s] && srcEn[s]) begin
        irqD     = 1'b1;
        pendD[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      irqQ     <= 1'b0;
      recheckQ <= 1'b0;
    end else begin
      pendQ    <= pendD;
      irqQ     <= irqD;
      recheckQ <= dataRd;
    end
  end

  assign pend = pendQ;
  assign irq  = irqQ;
endmodule

// File: rtl/serial_reg_data.sv
module serial_reg_data
  import serial_reg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic                 rxValid,
  input  logic [BYTE_W-1:0]    rxData,
  input  logic [NUM_SRC-1:0]   pend,
  output logic [BYTE_W-1:0]    rdata,
  output logic [BYTE_W-1:0]    txData,
  output logic                 dlab,
  output logic [NUM_SRC-1:0]   srcEn
);
  logic [BYTE_W-1:0] lcrQ, ierQ, mcrQ, divLoQ, divHiQ;
  logic [BYTE_W-1:0] iidVal, lsrVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lcrQ   <= '0;
      ierQ   <= '0;
      mcrQ   <= '0;
      divLoQ <= '0;
      divHiQ <= '0;
    end else begin
      if (strobe.wrLcr)   lcrQ   <= wdata;
      if (strobe.wrIer)   ierQ   <= wdata;
      if (strobe.wrMcr)   mcrQ   <= wdata;
      if (strobe.wrDivLo) divLoQ <= wdata;
      if (strobe.wrDivHi) divHiQ <= wdata;
    end
  end

  always_comb begin
    if (pend[SRC_RX])      iidVal = IID_RX;
    else if (pend[SRC_TX]) iidVal = IID_TX;
    else                   iidVal = IID_NONE;
  end

  always_comb begin
    lsrVal               = '0;
    lsrVal[LSR_DR_BIT]   = rxValid;
    lsrVal[LSR_THRE_BIT] = 1'b1;
    lsrVal[LSR_TEMT_BIT] = 1'b1;
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_RXDATA: rdata = rxValid ? rxData : '0;
      SEL_DIVLO:  rdata = divLoQ;
      SEL_IER:    rdata = ierQ;
      SEL_DIVHI:  rdata = divHiQ;
      SEL_IID:    rdata = iidVal;
      SEL_LCR:    rdata = lcrQ;
      SEL_MCR:    rdata = mcrQ;
      SEL_LSR:    rdata = lsrVal;
      default:    rdata = '0;
    endcase
  end

  assign txData = wdata;
  assign dlab   = lcrQ[CTRL_DIV_BIT];
  assign srcEn  = ierQ[NUM_SRC-1:0];
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import serial_reg_pkg::*;
#(
  parameter int IRQ_DELAY = 450
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  output logic       rxReady,
  output logic       txStrobe,
  output logic [7:0] txData,
  output logic       irq
);
  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] srcEn;
  logic               dlab;

  serial_reg_ctrl #(.IRQ_DELAY(IRQ_DELAY)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .ierBits  (busWdata[NUM_SRC-1:0]),
    .rxValid  (rxValid),
    .dlab     (dlab),
    .srcEn    (srcEn),
    .strobe   (strobe),
    .pend     (pend),
    .irq      (irq),
    .rxReady  (rxReady),
    .txStrobe (txStrobe)
  );

  serial_reg_data uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wdata   (busWdata),
    .rxValid (rxValid),
    .rxData  (rxData),
    .pend    (pend),
    .rdata   (busRdata),
    .txData  (txData),
    .dlab    (dlab),
    .srcEn   (srcEn)
  );
endmodule

// File: rtl/serial_reg_checker.sv
module serial_reg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWr,
  input logic [2:0] busAddr,
  input logic [1:0] enBits,
  input logic [7:0] busRdata,
  input logic       rxValid,
  input logic       rxReady,
  input logic       txStrobe,
  input logic       irq,
  input logic       dlab,
  input logic [1:0] srcEn
);
  assert_div_no_tx_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 3'd0 && dlab) |-> !txStrobe);

  assert_pop_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> (rxValid && busSel && !busWr && !dlab && busAddr == 3'd0));

  assert_ier_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 3'd1 && !dlab && enBits == 2'b00) |=> !irq);

  assert_post_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(|srcEn));

  assert_iid_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 3'd2) |-> $onehot0(busRdata) && busRdata inside {8'h01, 8'h02, 8'h04});

  assert_lsr_fixed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 3'd5) |-> busRdata == {1'b0, 2'b11, 4'b0000, rxValid});

  assert_scratch_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && (busAddr == 3'd7 || busAddr == 3'd6)) |-> busRdata == 8'h00);
endmodule

bind serial_reg_port serial_reg_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .enBits   (busWdata[1:0]),
  .busRdata (busRdata),
  .rxValid  (rxValid),
  .rxReady  (rxReady),
  .txStrobe (txStrobe),
  .irq      (irq),
  .dlab     (dlab),
  .srcEn    (srcEn)
);

// File: tb/serial_reg_port_bench.sv
`timescale 1ns/1ps
module serial_reg_port_bench;
  localparam int D = 450;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxReady, txStrobe, irq;
  logic [7:0] txData;

  int  nChk = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  logic [8:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  serial_reg_port #(.IRQ_DELAY(D)) u_serial_reg_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .txStrobe(txStrobe), .txData(txData), .irq(irq)
  );

  // monitor: compares each access cycle against the scoreboard queue
  always begin
    @(negedge clk);
    #1;
    if (busSel && rstN) begin
      logic [8:0] got;
      got = busWr ? {txStrobe, txData} : {rxReady, busRdata};
      nChk++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL unexpected access: got %h expected none", got);
      end else begin
        logic [8:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (got !== e) begin
          nFail++;
          $display("FAIL %s: got %h expected %h", t, got, e);
        end
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [8:0] e, input string t);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [8:0] e, input string t);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkIrq(input logic e, input string t);
    #1;
    nChk++;
    if (irq !== e) begin
      nFail++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    // R12 reset state
    chkIrq(1'b0, "R12 irq after reset");
    rd(3'd2, 9'h001, "R12 IID after reset");
    rd(3'd3, 9'h000, "R12 control byte after reset");
    rd(3'd1, 9'h000, "R12 enable byte after reset");
    rd(3'd5, 9'h060, "R10 status with source empty");

    // R1 divisor access
    wr(3'd3, 8'h83, 9'h083, "R1 set divisor access");
    wr(3'd0, 8'h12, 9'h012, "R1 divisor low write without strobe");
    wr(3'd1, 8'h34, 9'h034, "R1 divisor high write");
    rd(3'd0, 9'h012, "R1 divisor low read");
    rd(3'd1, 9'h034, "R1 divisor high read");
    wr(3'd3, 8'h03, 9'h003, "R1 clear divisor access");
    rd(3'd0, 9'h000, "R2 empty data read");
    rd(3'd1, 9'h000, "R1 enable byte unaffected by divisor writes");
    rd(3'd3, 9'h003, "R1 control byte readback");
    wr(3'd4, 8'h1B, 9'h01B, "R1 modem byte write");
    rd(3'd4, 9'h01B, "R1 modem byte readback");

    // R3 transmit
    wr(3'd0, 8'hA5, 9'h1A5, "R3 data write strobe");

    // R11 ignored offsets
    wr(3'd7, 8'h55, 9'h055, "R11 scratch write");
    rd(3'd7, 9'h000, "R11 scratch reads zero");
    wr(3'd2, 8'hC7, 9'h0C7, "R11 offset 2 write");
    rd(3'd3, 9'h003, "R11 control byte unchanged");
    rd(3'd2, 9'h001, "R11 IID unchanged");
    rd(3'd6, 9'h000, "R11 offset 6 reads zero");
    chkIrq(1'b0, "R11 no irq from ignored writes");

    // R4/R5/R6 transmit timer
    wr(3'd1, 8'h02, 9'h002, "R5 enable transmit");
    waitN(D - 1); chkIrq(1'b0, "R4 tx irq not before delay");
    waitN(1);     chkIrq(1'b1, "R4 tx irq at delay");
    rd(3'd2, 9'h002, "R7 IID transmit");
    rd(3'd2, 9'h001, "R7 IID read cleared transmit");
    chkIrq(1'b1, "R7 IID read keeps irq");
    wr(3'd0, 8'h3C, 9'h13C, "R9 data write");
    chkIrq(1'b0, "R9 data write drops irq");
    waitN(200);
    wr(3'd0, 8'h5A, 9'h15A, "R4 restart write");
    waitN(D - 1); chkIrq(1'b0, "R4 restart delays irq");
    waitN(1);     chkIrq(1'b1, "R4 irq after restart");

    // R5 cancel
    wr(3'd1, 8'h00, 9'h000, "R5 disable all");
    chkIrq(1'b0, "R5 disable drops irq");
    wr(3'd1, 8'h02, 9'h002, "R5 re-enable transmit");
    waitN(100);
    wr(3'd1, 8'h00, 9'h000, "R5 cancel running timer");
    waitN(D + 10); chkIrq(1'b0, "R5 cancelled timer stays silent");
    rd(3'd2, 9'h001, "R5 nothing pending after cancel");

    // R7/R8 receive and priority
    rxValid = 1'b1; rxData = 8'h77;
    rd(3'd5, 9'h061, "R10 status with byte waiting");
    wr(3'd1, 8'h03, 9'h003, "R5 enable both with data waiting");
    waitN(D - 1); chkIrq(1'b0, "R4 both not before delay");
    waitN(1);     chkIrq(1'b1, "R6 both posted");
    rd(3'd2, 9'h004, "R7 receive outranks transmit");
    rd(3'd2, 9'h004, "R7 receive still pending");
    rd(3'd0, 9'h177, "R2 data read pops byte");
    chkIrq(1'b0, "R8 data read drops irq");
    rxData = 8'h78;
    waitN(D);     chkIrq(1'b0, "R8 rearm not before delay plus one");
    waitN(1);     chkIrq(1'b1, "R8 rearmed receive posted");
    rd(3'd2, 9'h004, "R8 IID receive after rearm");
    rd(3'd0, 9'h178, "R2 second byte");
    rxValid = 1'b0; rxData = 8'h00;
    waitN(D + 5); chkIrq(1'b0, "R8 no rearm when source empty");

    // R6 no post without armed data
    wr(3'd1, 8'h01, 9'h001, "R6 enable receive, no data");
    waitN(D + 5); chkIrq(1'b0, "R6 no receive irq without data");
    rd(3'd2, 9'h001, "R6 nothing pending");

    waitN(3);
    nChk++;
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard: got %0d leftover expected 0", expQ.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule